// File: doc/BRIEF.md
# Page-Cached Address Translator

This block turns a 20-bit virtual address into an 18-bit physical address for 4 KB pages. The low 12 bits, the page offset, go through untouched. The 8-bit virtual page number is mapped to a 6-bit physical page number. Recent mappings are kept in an 8-entry buffer arranged as 4 sets of 2 ways. The set is picked by the two low page-number bits, and the other six bits are stored as the tag.

On a hit, the answer comes back in the cycle after the request is accepted. On a miss, the block stops taking requests and reads one entry from a flat page table in external memory. The entry's address is the table base plus the page number. If the entry is valid, the block stores it in the chosen way and returns the translation. If it is not valid, the block reports a fault and stores nothing.

Software-visible control is limited to two things. A base-register write retargets the table and also empties the buffer. A separate flush input empties the buffer in a single cycle.

Top module: `vat_xlate`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and pt_rd_en is 0. The buffer is empty, so the first request misses, and the table base is 0.
- R2: A translated address is {physical page, vaddr[11:0]}. With the entry at table address 0x01F holding page 0x15, virtual 0x1F213 gives 0x15213.
- R3: The set is vaddr[13:12] and the tag is vaddr[19:14]. Two addresses that differ only in bits [11:0] use the same entry, and at most one way matches.
- R4: On a miss, pt_rd_en is high for exactly one cycle, the cycle after acceptance. pt_rd_addr is (base + vaddr[19:12]) modulo 2^12. pt_rd_data is taken in the following cycle.
- R5: A table entry is 7 bits wide: bit 6 is valid and bits 5:0 are the physical page. If valid is 0, the response has rsp_fault=1 and rsp_paddr=0, and nothing is stored, so a repeat of the request reads the table again.
- R6: On a hit, rsp_valid rises in the cycle after acceptance. No table read is made, and req_ready stays 1.
- R7: On a miss, req_ready is 0 from the cycle after acceptance until the response. The response arrives in the third cycle after acceptance.
- R8: After a valid refill, the next request to the same page hits without a table read.
- R9: When a set is refilled, an empty way is used first. If both ways are full, the least recently used way is replaced. Hits count as use.
- R10: A flush pulse empties every entry by the next cycle, and req_ready is 0 while flush is high.
- R11: A base write loads the new base, empties the buffer, and drops req_ready for that cycle.
- R12: If a flush falls on the same edge as a refill, the flush wins. The response is still delivered, but the entry is not kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 20 | Virtual address |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 18 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Table entry was invalid |
| pt_rd_en | output | 1 | Table read strobe |
| pt_rd_addr | output | 12 | Table entry address |
| pt_rd_data | input | 7 | Entry, valid the cycle after pt_rd_en |
| base_wr_en | input | 1 | Load table base (also flushes) |
| base_wr_data | input | 12 | New table base |
| flush | input | 1 | Empty the buffer |

## Verification
The flush can land on the same clock edge that writes a refilled entry. To provoke this, the bench raises flush in the cycle where table data is present during a miss. Two things are then judged. First, the response must still arrive on time with the correct address. Second, a repeat of the same page must miss and read the table again, which shows the flush overrode the write. A hit followed later by a base write is also covered: after the write, the same page must be fetched from the new base address.

// File: rtl/vat_pkg.sv
package vat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_DATA = 2'd2
  } walk_st_e;
endpackage

// File: rtl/vat_tlb.sv
module vat_tlb #(
  parameter int VPN_W = 8,
  parameter int PPN_W = 6,
  parameter int SET_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             touch_en,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn
);
  localparam int TAG_W = VPN_W - SET_W;
  localparam int SETS  = 1 << SET_W;
  localparam int WAYS  = 2;
  localparam int ENT_W = TAG_W + PPN_W;

  logic [SET_W-1:0] lk_set, fl_set;
  logic [WAYS-1:0]  way_hit, fl_vld;
  logic [PPN_W-1:0] way_ppn [WAYS];
  logic [SETS-1:0]  lru_q;   // per set: the way to replace next
  logic             victim;
  logic             lk_way;

  assign lk_set = lk_vpn[SET_W-1:0];
  assign fl_set = fill_vpn[SET_W-1:0];

  // empty way first, then least recently used
  assign victim = !fl_vld[0] ? 1'b0 : (!fl_vld[1] ? 1'b1 : lru_q[fl_set]);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [ENT_W-1:0] ent_q [SETS];
    logic [SETS-1:0]  vld_q;
    logic             wr;

    assign wr = fill_en && (victim == 1'(w));

    always_ff @(posedge clk) begin
      if (wr) ent_q[fl_set] <= {fill_vpn[VPN_W-1:SET_W], fill_ppn};
    end

    // flush beats a same-edge refill
    always_ff @(posedge clk) begin
      if (rst || flush) vld_q <= '0;
      else if (wr)      vld_q[fl_set] <= 1'b1;
    end

    assign way_hit[w] = vld_q[lk_set] &&
                        (ent_q[lk_set][ENT_W-1:PPN_W] == lk_vpn[VPN_W-1:SET_W]);
    assign way_ppn[w] = ent_q[lk_set][PPN_W-1:0];
    assign fl_vld[w]  = vld_q[fl_set];
  end

  assign lk_hit = |way_hit;
  assign lk_way = way_hit[1];
  assign lk_ppn = way_hit[1] ? way_ppn[1] : way_ppn[0];

  always_ff @(posedge clk) begin
    if (rst) lru_q <= '0;
    else begin
      if (touch_en) lru_q[lk_set] <= ~lk_way;
      if (fill_en)  lru_q[fl_set] <= ~victim;
    end
  end

  a_r3_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_hit));
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> !lk_hit);
endmodule

// File: rtl/vat_walk.sv
module vat_walk
  import vat_pkg::*;
#(
  parameter int VA_W  = 20,
  parameter int PA_W  = 18,
  parameter int OFF_W = 12,
  parameter int PTA_W = 12,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int PTE_W = PPN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_any,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  input  logic [PTA_W-1:0] base,
  output logic             pt_rd_en,
  output logic [PTA_W-1:0] pt_rd_addr,
  input  logic [PTE_W-1:0] pt_rd_data,
  output logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_hit,
  input  logic [PPN_W-1:0] lk_ppn,
  output logic             touch_en,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PPN_W-1:0] fill_ppn
);
  walk_st_e        st_q;
  logic [VA_W-1:0] va_q;
  logic            accept;
  logic            pte_ok;

  assign req_ready = (st_q == ST_IDLE) && !flush_any;
  assign accept    = req_valid && req_ready;
  assign lk_vpn    = req_vaddr[VA_W-1:OFF_W];
  assign touch_en  = accept && lk_hit;
  assign pt_rd_en  = (st_q == ST_RD);
  assign pte_ok    = pt_rd_data[PTE_W-1];
  assign fill_en   = (st_q == ST_DATA) && pte_ok;
  assign fill_vpn  = va_q[VA_W-1:OFF_W];
  assign fill_ppn  = pt_rd_data[PPN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      va_q       <= '0;
      pt_rd_addr <= '0;
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_fault  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          if (lk_hit) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_paddr <= {lk_ppn, req_vaddr[OFF_W-1:0]};
          end else begin
            va_q       <= req_vaddr;
            pt_rd_addr <= base + PTA_W'(lk_vpn);
            st_q       <= ST_RD;
          end
        end
        ST_RD:   st_q <= ST_DATA;
        ST_DATA: begin
          rsp_valid <= 1'b1;
          rsp_fault <= !pte_ok;
          rsp_paddr <= pte_ok ? {fill_ppn, va_q[OFF_W-1:0]} : '0;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r6_hit_no_read: assert property (@(posedge clk) disable iff (rst)
    (accept && lk_hit) |=> (rsp_valid && !pt_rd_en));
  a_r7_miss_latency: assert property (@(posedge clk) disable iff (rst)
    (accept && !lk_hit) |=> pt_rd_en ##1 !rsp_valid ##1 rsp_valid);
  a_r4_single_read: assert property (@(posedge clk) disable iff (rst)
    pt_rd_en |=> !pt_rd_en);
  a_r5_fault_nofill: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> !$past(fill_en));
endmodule

// File: rtl/vat_xlate.sv
module vat_xlate #(
  parameter int VA_W  = 20,
  parameter int PA_W  = 18,
  parameter int OFF_W = 12,
  parameter int SET_W = 2,
  parameter int PTA_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  output logic                   req_ready,
  output logic                   rsp_valid,
  output logic [PA_W-1:0]        rsp_paddr,
  output logic                   rsp_fault,
  output logic                   pt_rd_en,
  output logic [PTA_W-1:0]       pt_rd_addr,
  input  logic [PA_W-OFF_W:0]    pt_rd_data,
  input  logic                   base_wr_en,
  input  logic [PTA_W-1:0]       base_wr_data,
  input  logic                   flush
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic [PTA_W-1:0] base_q;
  logic             flush_any;
  logic [VPN_W-1:0] lk_vpn, fill_vpn;
  logic [PPN_W-1:0] lk_ppn, fill_ppn;
  logic             lk_hit, touch_en, fill_en;

  assign flush_any = flush || base_wr_en;

  always_ff @(posedge clk) begin
    if (rst)             base_q <= '0;
    else if (base_wr_en) base_q <= base_wr_data;
  end

  vat_walk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .PTA_W(PTA_W)) u_walk (
    .clk(clk), .rst(rst), .flush_any(flush_any),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .base(base_q), .pt_rd_en(pt_rd_en), .pt_rd_addr(pt_rd_addr), .pt_rd_data(pt_rd_data),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .touch_en(touch_en),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn)
  );

  vat_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SET_W(SET_W)) u_tlb (
    .clk(clk), .rst(rst), .flush(flush_any),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .touch_en(touch_en),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn)
  );

  a_r11_base_flush_ready: assert property (@(posedge clk) disable iff (rst)
    base_wr_en |-> !req_ready);
endmodule

// File: tb/vat_xlate_tb.sv
module vat_xlate_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, req_valid, req_ready, rsp_valid, rsp_fault, pt_rd_en, base_wr_en, flush;
  logic [19:0] req_vaddr;
  logic [17:0] rsp_paddr;
  logic [11:0] pt_rd_addr, base_wr_data, base_m;
  logic [6:0]  pt_rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  vat_xlate u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .pt_rd_en(pt_rd_en), .pt_rd_addr(pt_rd_addr), .pt_rd_data(pt_rd_data),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data), .flush(flush)
  );

  // page-table model: entries with address bits 7:6 = 11 are invalid
  function automatic logic [6:0] pte_of(input logic [11:0] a);
    return {a[7:6] != 2'b11, a[5:0] ^ 6'h0A ^ a[11:6]};
  endfunction

  always_ff @(posedge clk) if (pt_rd_en) pt_rd_data <= pte_of(pt_rd_addr);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic xlate(input logic [19:0] va, input bit exp_hit, input int flush_lat, input string rq);
    logic [11:0] a;
    logic [6:0]  e;
    int lat, reads;
    a = base_m + 12'(va[19:12]);
    e = pte_of(a);
    @(negedge clk); req_valid = 1'b1; req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0; lat = 1; reads = 0;
    if (exp_hit) chk({rq, " R6 ready kept on hit"}, 32'(req_ready), 1);
    else begin
      chk({rq, " R7 ready low in walk"}, 32'(req_ready), 0);
      chk({rq, " R4 table address"}, 32'(pt_rd_addr), 32'(a));
    end
    while (!rsp_valid && lat < 8) begin
      reads += 32'(pt_rd_en);
      if (lat == flush_lat) flush = 1'b1;
      @(negedge clk); flush = 1'b0; lat++;
    end
    chk({rq, exp_hit ? " R6 hit latency" : " R7 miss latency"}, 32'(lat), exp_hit ? 1 : 3);
    chk({rq, " R4/R8 table reads"}, 32'(reads), exp_hit ? 0 : 1);
    chk({rq, " R5 fault flag"}, 32'(rsp_fault), 32'(!e[6]));
    chk({rq, " R2 paddr"}, 32'(rsp_paddr), e[6] ? 32'({e[5:0], va[11:0]}) : 0);
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    #1 chk("R10 ready low during flush", 32'(req_ready), 0);
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic write_base(input logic [11:0] v);
    @(negedge clk); base_wr_en = 1'b1; base_wr_data = v;
    #1 chk("R11 ready low during base write", 32'(req_ready), 0);
    @(negedge clk); base_wr_en = 1'b0; base_m = v;
  endtask

  // {expect_hit, vaddr}, base 0, after 0x1F213 is loaded
  localparam logic [20:0] TBL [8] = '{
    {1'b1, 20'h1FABC}, {1'b0, 20'h00123}, {1'b1, 20'h00FFF}, {1'b0, 20'h2E001},
    {1'b0, 20'hC5010}, {1'b0, 20'hC5010}, {1'b1, 20'h2E7FF}, {1'b1, 20'h1F000}
  };

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; flush = 1'b0;
    base_wr_en = 1'b0; base_wr_data = '0; base_m = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 1);
    chk("R1 no response after reset", 32'(rsp_valid), 0);
    chk("R1 no table read after reset", 32'(pt_rd_en), 0);

    xlate(20'h1F213, 1'b0, 0, "R1 R2 worked example");
    chk("R2 worked example 0x15213", 32'(rsp_paddr), 32'h15213);

    for (int i = 0; i < 8; i++)
      xlate(TBL[i][19:0], TBL[i][20], 0, "R3 R5 R8 table");

    // R9: set 0 replacement order
    xlate(20'h04000, 1'b0, 0, "R9 fill empty way");
    xlate(20'h00ABC, 1'b1, 0, "R9 touch");
    xlate(20'h08000, 1'b0, 0, "R9 evict lru");
    xlate(20'h00000, 1'b1, 0, "R9 recent kept");
    xlate(20'h04000, 1'b0, 0, "R9 evicted refetch");

    pulse_flush();
    xlate(20'h00000, 1'b0, 0, "R10 miss after flush");

    xlate(20'h2E001, 1'b0, 2, "R12 flush on refill");
    xlate(20'h2E001, 1'b0, 0, "R12 refill dropped");
    xlate(20'h2E001, 1'b1, 0, "R12 later hit");

    write_base(12'h100);
    xlate(20'h1F213, 1'b0, 0, "R11 new base");
    chk("R11 new base paddr", 32'(rsp_paddr), 32'h11213);
    xlate(20'h1F213, 1'b1, 0, "R11 hit after fetch");

    write_base(12'hFF0);
    xlate(20'h1F213, 1'b0, 0, "R4 address wrap");
    chk("R4 wrap paddr", 32'(rsp_paddr), 32'h05213);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule